// File: doc/BRIEF.md
# Sixteen-bit timer with single-pulse output

The block is a 16-bit up-counter, clocked by a divided system clock or by an external clock input. It has one capture input and two compare outputs. In normal operation the capture input stores the counter value on its selected edge. Each compare channel drives a programmed level onto its pin when the counter reaches the channel's compare value, and raises a flag.

The single-pulse mode is the main feature. When an active edge arrives on the capture input, the counter restarts at 0xFFFC and compare pin 1 takes the "during" level. When the counter reaches compare value 1, the pin returns to the "after" level. This gives a pulse whose width is set by compare value 1 and the tick rate.

Software drives the block through a small write/read register port. Force bits pin a compare output to its level bit. The flags are combined into one interrupt request.

Top module: `opm_timer`

## Requirements
- R1: clock select field (ctrl B bits 5:4) codes 00, 01 and 10 advance the counter once every 2, 4 and 8 system clocks respectively; the counter is read at address 5.
- R2: clock select code 11 advances the counter once per rising edge of `ext_clk`, which passes through a two-flop synchroniser; the increment lands on the third clock edge after the input rises.
- R3: with single-pulse mode on (ctrl B bit 2) and PWM off, an active capture edge loads 0xFFFC into the counter and drives compare pin 1 to the during level (ctrl A bit 1); the effect appears on the third clock edge after the pin change; the pre-load counter value goes to the capture register (address 6).
- R4: in single-pulse mode, when the counter reaches compare value 1 (address 2), pin 1 switches to the after level (ctrl A bit 0) on that same edge, and compare flag 1 (status bit 1) is not set.
- R5: in single-pulse mode a compare-2 match (address 3) still sets compare flag 2 (status bit 2), which requests an interrupt when ctrl A bit 6 is set.
- R6: every active capture edge sets the capture flag (status bit 0); `irq` is high only while a set flag has its enable bit set (capture: ctrl A bit 5, compares: ctrl A bit 6).
- R7: ctrl A bit 4 selects the active capture edge: 1 rising, 0 falling; the other edge sets no flag.
- R8: when the PWM bit (ctrl B bit 3) and the single-pulse bit are both set, a capture edge does not preset the counter and does not change pin 1.
- R9: force bit i (ctrl A bit 2 for channel 1, bit 3 for channel 2) copies level bit i (ctrl A bit 0, bit 1) straight to compare pin i, and a forced channel never sets its compare flag.
- R10: force bits are set by writing 1 and cannot be cleared by any register write; only reset clears them.
- R11: compare pin i is driven low unless its output enable (ctrl B bit 0 for pin 1, bit 1 for pin 2) is set.
- R12: outside single-pulse mode, a compare match on channel i drives level bit i onto pin i and sets compare flag i, in the edge where the counter reaches the value.
- R13: writing to address 4 clears each status flag whose data bit is 1; all flags and outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_pin | input | 1 | Capture input, asynchronous |
| ext_clk | input | 1 | External timer clock, asynchronous |
| cmp_out1 | output | 1 | Compare output 1 (pulse output) |
| cmp_out2 | output | 1 | Compare output 2 |
| irq | output | 1 | Interrupt request |

## Verification
A capture edge or an external clock edge takes effect on the third rising clock edge after the input changes: two synchroniser edges, then the registering edge. The bench changes these inputs at a falling edge, counts three falling edges, and samples there. Compare matches change the pin and the flag in the same edge that brings the counter to the compare value. The bench therefore polls at falling edges and, at the first sample where the flag or pin has moved, expects the counter to equal the compare value. Divider checks read the counter across a window that is a multiple of eight clocks, so the expected advance does not depend on the prescaler phase.

// File: rtl/otm_pkg.sv
package otm_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int N_CMP  = 2;
  localparam int PRE_W  = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t PRESET_VAL = ~cnt_t'(3);

  localparam logic [ADDR_W-1:0] ADR_CTRL_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL_B = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP1   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMP2   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CAPT   = 3'd6;

  // prescaler mask: tick when all masked bits are ones
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'b001;
      2'b01:   return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // next counter value: preset has priority over the increment
  function automatic cnt_t count_step(input cnt_t cur, input logic preset);
    return preset ? PRESET_VAL : cnt_t'(cur + cnt_t'(1));
  endfunction
endpackage

// File: rtl/otm_edge_sync.sv
module otm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];

  assert_one_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_one_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/otm_prescaler.sv
module otm_prescaler
  import otm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       ext_rise,
  output logic       tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  assign mask = div_mask(clk_sel);
  assign tick = (clk_sel == 2'b11) ? ext_rise : ((pre & mask) == mask);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel != 2'b11) |=> (clk_sel == 2'b11 || !tick));
endmodule

// File: rtl/otm_counter.sv
module otm_counter
  import otm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic preset,
  output cnt_t cnt_q,
  output cnt_t cnt_nxt,
  output logic upd
);
  assign upd     = tick | preset;
  assign cnt_nxt = count_step(cnt_q, preset);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_nxt;
  end

  assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !preset) |=> cnt_q == cnt_t'($past(cnt_q) + 1'b1));
  assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> cnt_q == PRESET_VAL);
endmodule

// File: rtl/otm_cmp_chan.sv
module otm_cmp_chan #(
  parameter bit PULSE_CH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic start,
  input  logic opm_on,
  input  logic force_on,
  input  logic oe,
  input  logic lvl_match,
  input  logic lvl_start,
  output logic flag_set,
  output logic pin
);
  logic st;
  logic start_here;

  assign start_here = PULSE_CH && start;

  always_ff @(posedge clk) begin
    if (!rst_n)          st <= 1'b0;
    else if (start_here) st <= lvl_start;
    else if (match)      st <= lvl_match;
  end

  assign flag_set = match && !force_on && !(PULSE_CH && opm_on);
  assign pin      = oe ? (force_on ? lvl_match : st) : 1'b0;

  assert_pulse_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_here |=> st == $past(lvl_start));
  assert_match_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !start_here) |=> st == $past(lvl_match));
endmodule

// File: rtl/opm_timer.sv
module opm_timer
  import otm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_pin,
  input  logic              ext_clk,
  output logic              cmp_out1,
  output logic              cmp_out2,
  output logic              irq
);
  // control state
  logic [N_CMP-1:0] lvl;
  logic [N_CMP-1:0] force_q;
  logic [N_CMP-1:0] oe;
  logic             edge_rise, cap_ie, cmp_ie;
  logic             pulse_mode, pwm_mode;
  logic [1:0]       clk_sel;
  cnt_t             cmp_val [N_CMP];
  cnt_t             capt_q;
  logic [N_CMP:0]   flags;

  // internal events
  logic cap_r, cap_f, ext_r, ext_f_unused;
  logic cap_evt, opm_on, opm_start, tick, upd;
  cnt_t cnt_q, cnt_nxt;
  logic [N_CMP-1:0] match, flag_set, pins;
  logic [N_CMP:0]   flag_clr, flag_hit;

  otm_edge_sync #(.STAGES(2)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_pin), .rise(cap_r), .fall(cap_f));
  otm_edge_sync #(.STAGES(2)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_r), .fall(ext_f_unused));

  assign cap_evt   = edge_rise ? cap_r : cap_f;
  assign opm_on    = pulse_mode && !pwm_mode;
  assign opm_start = opm_on && cap_evt;

  otm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_rise(ext_r), .tick(tick));

  otm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preset(opm_start),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .upd(upd));

  for (genvar i = 0; i < N_CMP; i++) begin : g_chan
    assign match[i] = upd && (cnt_nxt == cmp_val[i]);
    otm_cmp_chan #(.PULSE_CH(i == 0)) u_chan (
      .clk(clk), .rst_n(rst_n), .match(match[i]), .start(opm_start),
      .opm_on(opm_on), .force_on(force_q[i]), .oe(oe[i]),
      .lvl_match(lvl[i]), .lvl_start(lvl[N_CMP-1]),
      .flag_set(flag_set[i]), .pin(pins[i]));
  end

  assign cmp_out1 = pins[0];
  assign cmp_out2 = pins[1];

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl        <= '0;
      force_q    <= '0;
      edge_rise  <= 1'b0;
      cap_ie     <= 1'b0;
      cmp_ie     <= 1'b0;
      oe         <= '0;
      pulse_mode <= 1'b0;
      pwm_mode   <= 1'b0;
      clk_sel    <= 2'b00;
      for (int i = 0; i < N_CMP; i++) cmp_val[i] <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL_A: begin
          lvl       <= wr_data[1:0];
          force_q   <= force_q | wr_data[3:2];
          edge_rise <= wr_data[4];
          cap_ie    <= wr_data[5];
          cmp_ie    <= wr_data[6];
        end
        ADR_CTRL_B: begin
          oe         <= wr_data[1:0];
          pulse_mode <= wr_data[2];
          pwm_mode   <= wr_data[3];
          clk_sel    <= wr_data[5:4];
        end
        ADR_CMP1: cmp_val[0] <= wr_data;
        ADR_CMP2: cmp_val[1] <= wr_data;
        default: ;
      endcase
    end
  end

  // capture register and flags
  assign flag_clr = (wr_en && wr_addr == ADR_STAT) ? wr_data[N_CMP:0] : '0;
  assign flag_hit = {flag_set, cap_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capt_q <= '0;
      flags  <= '0;
    end else begin
      if (cap_evt) capt_q <= cnt_q;
      flags <= (flags & ~flag_clr) | flag_hit;
    end
  end

  assign irq = (flags[0] & cap_ie) | ((|flags[N_CMP:1]) & cmp_ie);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL_A: rd_data = CNT_W'({cmp_ie, cap_ie, edge_rise, force_q, lvl});
      ADR_CTRL_B: rd_data = CNT_W'({clk_sel, pwm_mode, pulse_mode, oe});
      ADR_CMP1:   rd_data = cmp_val[0];
      ADR_CMP2:   rd_data = cmp_val[1];
      ADR_STAT:   rd_data = CNT_W'(flags);
      ADR_COUNT:  rd_data = cnt_q;
      ADR_CAPT:   rd_data = capt_q;
      default:    rd_data = '0;
    endcase
  end

  assert_force_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_q[0] |=> force_q[0]);
  assert_force_sticky2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_q[1] |=> force_q[1]);
  assert_no_pulse_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opm_on && match[0] && !flags[1]) |=> !flags[1]);
  assert_cmp2_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match[1] && !force_q[1]) |=> flags[2]);
  assert_pwm_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |-> !opm_start);
  assert_capture_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flags[0]);
endmodule

// File: tb/test_opm_timer.sv
module test_opm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cap_pin = 1'b0;
  logic        ext_clk = 1'b0;
  logic        cmp_out1, cmp_out2, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opm_timer i_opm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_pin(cap_pin), .ext_clk(ext_clk), .cmp_out1(cmp_out1),
    .cmp_out2(cmp_out2), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0, c1, v;
    int div;
    wait_neg(3);
    rst_n = 1'b1;
    // R13 reset state
    rd(3'd5, v); chk("R13 counter after reset", v, 0);
    rd(3'd4, v); chk("R13 flags after reset", v, 0);
    chk("R13 outputs after reset", {cmp_out1, cmp_out2, irq}, 0);

    // R1 divider sweep
    for (int s = 0; s < 3; s++) begin
      wr(3'd1, 16'(s << 4));
      div = 2 << s;
      rd(3'd5, c0);
      wait_neg(64);
      rd(3'd5, c1);
      chk($sformatf("R1 advance sel=%0d", s), 16'(c1 - c0), 16'(64 / div));
    end

    // R2 external clock
    wr(3'd1, 16'h0030);
    wait_neg(4);
    rd(3'd5, c0);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1'b1; wait_neg(4);
      ext_clk = 1'b0; wait_neg(4);
    end
    rd(3'd5, c1);
    chk("R2 external edges counted", 16'(c1 - c0), 5);
    ext_clk = 1'b1; wait_neg(2);
    rd(3'd5, c0);
    wait_neg(1);
    rd(3'd5, c1);
    chk("R2 increment on third edge", 16'(c1 - c0), 1);
    ext_clk = 1'b0;

    // R3/R4/R5 single pulse, rising edge, pin1 during=1 after=0
    wr(3'd2, 16'h0010);
    wr(3'd3, 16'h0005);
    wr(3'd0, 16'h0012);
    wr(3'd1, 16'h0007);
    wr(3'd4, 16'h0007);
    cap_pin = 1'b1;
    wait_neg(2);
    rd(3'd5, c0);
    wait_neg(1);
    rd(3'd5, v); chk("R3 preset value", v, 16'hFFFC);
    chk("R3 pin1 during level", cmp_out1, 1);
    rd(3'd6, v); chk("R3 capture register", v, c0);
    rd(3'd4, v); chk("R6 capture flag set", v[0], 1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!cmp_out1) break;
    end
    chk("R4 pin1 back to after level", cmp_out1, 0);
    rd(3'd5, v); chk("R4 counter at compare 1", v, 16'h0010);
    rd(3'd4, v); chk("R4 compare flag 1 stays clear", v[1], 0);
    chk("R5 compare flag 2 set in pulse mode", v[2], 1);

    // R6 / R5 / R13 interrupt gating and clearing
    chk("R6 irq gated off", irq, 0);
    wr(3'd0, 16'h0032);
    chk("R6 irq with capture enable", irq, 1);
    wr(3'd4, 16'h0001);
    chk("R6 irq after capture flag clear", irq, 0);
    wr(3'd0, 16'h0052);
    chk("R5 irq from compare 2", irq, 1);
    wr(3'd4, 16'h0007);
    rd(3'd4, v); chk("R13 flags cleared", v, 0);
    chk("R13 irq low after clear", irq, 0);

    // R7 falling edge select
    wr(3'd0, 16'h0002);
    cap_pin = 1'b0;
    wait_neg(3);
    rd(3'd5, v); chk("R7 falling edge presets", v, 16'hFFFC);
    chk("R7 pin1 during level", cmp_out1, 1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!cmp_out1) break;
    end
    wr(3'd4, 16'h0007);
    cap_pin = 1'b1;
    wait_neg(6);
    rd(3'd4, v); chk("R7 rising edge ignored", v[0], 0);

    // R8 PWM precedence
    wr(3'd1, 16'h000F);
    wr(3'd4, 16'h0007);
    cap_pin = 1'b0;
    wait_neg(3);
    rd(3'd5, v); chk("R8 no preset with PWM", v == 16'hFFFC, 0);
    chk("R8 pin1 unchanged", cmp_out1, 0);
    rd(3'd4, v); chk("R8 capture flag still set", v[0], 1);

    // R12 normal compare
    wr(3'd1, 16'h0003);
    wr(3'd0, 16'h0001);
    rd(3'd5, c0);
    wr(3'd2, 16'(c0 + 16'd8));
    wr(3'd4, 16'h0007);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      rd(3'd4, v);
      if (v[1]) break;
    end
    chk("R12 compare flag 1 set", v[1], 1);
    rd(3'd5, v); chk("R12 counter at match", v, 16'(c0 + 16'd8));
    chk("R12 pin1 takes level", cmp_out1, 1);

    // R9 / R10 / R11 forcing
    wr(3'd0, 16'h0004);
    chk("R9 forced pin1 low", cmp_out1, 0);
    wr(3'd0, 16'h0001);
    chk("R9 forced pin1 follows level", cmp_out1, 1);
    rd(3'd0, v); chk("R10 force bit kept", v[2], 1);
    wr(3'd1, 16'h0002);
    chk("R11 pin1 disabled", cmp_out1, 0);
    wr(3'd1, 16'h0003);
    rd(3'd5, c0);
    wr(3'd2, 16'(c0 + 16'd8));
    wr(3'd4, 16'h0007);
    wait_neg(40);
    rd(3'd4, v); chk("R9 forced channel sets no flag", v[1], 0);
    wr(3'd0, 16'h000A);
    chk("R9 forced pin2 high", cmp_out2, 1);
    wr(3'd0, 16'h0000);
    chk("R10 forced pin2 follows level low", cmp_out2, 0);
    rd(3'd0, v); chk("R10 both force bits kept", v[3:2], 2'b11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule